// File: doc/BRIEF.md
# Edge-Timing Numerically Controlled Oscillator

This block is a numerically controlled oscillator that does not produce sine samples. Instead it reports each period as a clock-aligned edge event together with a sub-clock timing code. A phase accumulator gains the active frequency word on every system clock. The nominal system clock is 100 MHz. When an update changes the value of a chosen accumulator bit (the tap), the block reports an edge. With the edge it gives the accumulator bits just under the tap, left-aligned, as a fraction of one clock. An external delay generator uses that fraction to place the true edge between clock ticks.

One cycle before each edge report, an early-warning strobe comes out together with the frequency word of that update. A delay generator can use these to load its interval before the edge arrives. Picking a lower tap gives twice as many edges per lower bit, so a wide frequency range needs no extra divider. The frequency word and the tap are taken only on a load strobe. The two are applied together, so an edge is never reported with a fraction or word from a different setting.

The edge outputs form a valid-only stream: `edge_o` qualifies `frac_o` and `edge_word_o` for one cycle. There is no ready input. A frequency source cannot stall, so the consumer must take every report in the cycle it appears. The tap select must be below the accumulator width.

Top module: `nco_edge_gen`

## Requirements
- R1: On every clock out of reset, the phase advances by the active frequency word, modulo 2^ACC_W.
- R2: `edge_o` is high in the cycle two clocks after the edge that performs an update. It is high only when that update changed the value of the tap bit `phase[tap]`; otherwise it is low.
- R3: `frac_o` gives the accumulator bits just below the tap after the same update, left-aligned. For tap t, bit `FRAC_W-1-i` of `frac_o` is `phase[t-1-i]`, and it is 0 where `t-1-i` is negative.
- R4: `early_o` is high exactly one cycle before each `edge_o` pulse, and each `early_o` is followed by `edge_o` in the next cycle.
- R5: `early_word_o`, and one cycle later `edge_word_o`, give the frequency word that was used for the reported update.
- R6: When `load_i` is high at a clock edge, `freq_word_i` and `tap_sel_i` are captured. The update at the following edge is the first one to use them.
- R7: While `load_i` is low, changes on `freq_word_i` and `tap_sel_i` have no effect on any output.
- R8: Synchronous reset clears the phase to 0, the word to 0 and the tap to ACC_W-1, and holds `edge_o`, `early_o` and every code output at 0. No edge is reported until the first real tap transition.
- R9: With the same word, selecting tap t-1 gives twice as many edges as tap t. For example, word 0x0100 gives 32 edges in 512 clocks at tap 12 and 64 at tap 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| load_i | input | 1 | Capture strobe for word and tap |
| freq_word_i | input | ACC_W | Frequency word to load |
| tap_sel_i | input | $clog2(ACC_W) | Tap bit index to load |
| early_o | output | 1 | Warning one cycle before an edge |
| early_word_o | output | ACC_W | Word of the upcoming edge's update |
| edge_o | output | 1 | Edge report, valid for one cycle |
| frac_o | output | FRAC_W | Sub-clock fraction below the tap |
| edge_word_o | output | ACC_W | Word of the reported update |

## Verification
On every cycle, the assertions check four things. The threshold carry test must agree with a direct comparison of the tap bit before and after the sum. The early warning and the edge must pair one to one. The word and tap must stay put without a load. The outputs must be quiet right after reset. Only the bench's scenarios can show the actual fraction values, the exact cycle at which a new word first takes effect, the doubling of edge count per tap step, and behaviour when the word's own tap bit is set or the tap is bit 0. The bench shows these by comparing every output on every clock against a behavioural queue model.

// File: rtl/nco_edge_pkg.sv
package nco_edge_pkg;
  localparam int unsigned NCO_ACC_W_DEF  = 16;
  localparam int unsigned NCO_FRAC_W_DEF = 8;
endpackage

// File: rtl/nco_phase_acc.sv
module nco_phase_acc #(
  parameter int unsigned ACC_W = 16,
  parameter int unsigned SEL_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic [ACC_W-1:0] freq_word_i,
  input  logic [SEL_W-1:0] tap_sel_i,
  output logic [ACC_W-1:0] phase_o,
  output logic [ACC_W-1:0] word_o,
  output logic [SEL_W-1:0] tap_o
);
  logic [ACC_W-1:0] phase_q, word_q;
  logic [SEL_W-1:0] tap_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= '0;
      word_q  <= '0;
      tap_q   <= SEL_W'(ACC_W - 1);
    end else begin
      phase_q <= phase_q + word_q;
      if (load_i) begin
        word_q <= freq_word_i;
        tap_q  <= tap_sel_i;
      end
    end
  end

  assign phase_o = phase_q;
  assign word_o  = word_q;
  assign tap_o   = tap_q;

  // R7: setting holds without a load strobe
  p_setting_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !load_i |=> ($stable(word_q) && $stable(tap_q)));

  // R8: phase starts from zero after reset
  p_phase_cleared_r8: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (phase_q == '0));
endmodule

// File: rtl/nco_cross_detect.sv
module nco_cross_detect #(
  parameter int unsigned ACC_W  = 16,
  parameter int unsigned SEL_W  = 4,
  parameter int unsigned FRAC_W = 8
) (
  input  logic [ACC_W-1:0]  phase_i,
  input  logic [ACC_W-1:0]  word_i,
  input  logic [SEL_W-1:0]  tap_i,
  output logic              toggle_o,
  output logic [FRAC_W-1:0] frac_o
);
  logic [ACC_W-1:0] tap_weight, low_mask, low_phase, low_word, sum;
  logic [ACC_W:0]   threshold;
  logic             carry_in;

  always_comb begin
    tap_weight = ACC_W'(1) << tap_i;
    low_mask   = tap_weight - ACC_W'(1);
    low_phase  = phase_i & low_mask;
    low_word   = word_i & low_mask;
    // carry reaches the tap when the lower phase meets weight minus lower word
    threshold  = {1'b0, tap_weight} - {1'b0, low_word};
    carry_in   = ({1'b0, low_phase} >= threshold);
    toggle_o   = carry_in ^ word_i[tap_i];
    sum        = phase_i + word_i;
  end

  always_comb begin
    for (int i = 0; i < int'(FRAC_W); i++) begin
      int idx;
      idx = int'(tap_i) - 1 - i;
      frac_o[FRAC_W-1-i] = (idx >= 0) ? sum[idx[SEL_W-1:0]] : 1'b0;
    end
  end

  // R2: threshold carry test matches a direct tap-bit comparison
  always_comb begin
    if (!$isunknown({phase_i, word_i, tap_i}))
      p_toggle_match_r2: assert (toggle_o == (sum[tap_i] ^ phase_i[tap_i]));
  end
endmodule

// File: rtl/nco_edge_pipe.sv
module nco_edge_pipe #(
  parameter int unsigned ACC_W  = 16,
  parameter int unsigned FRAC_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              toggle_i,
  input  logic [FRAC_W-1:0] frac_i,
  input  logic [ACC_W-1:0]  word_i,
  output logic              early_o,
  output logic [ACC_W-1:0]  early_word_o,
  output logic              edge_o,
  output logic [FRAC_W-1:0] frac_o,
  output logic [ACC_W-1:0]  edge_word_o
);
  logic [FRAC_W-1:0] s1_frac;

  always_ff @(posedge clk) begin
    if (rst) begin
      early_o      <= 1'b0;
      early_word_o <= '0;
      s1_frac      <= '0;
      edge_o       <= 1'b0;
      frac_o       <= '0;
      edge_word_o  <= '0;
    end else begin
      early_o      <= toggle_i;
      early_word_o <= word_i;
      s1_frac      <= frac_i;
      edge_o       <= early_o;
      frac_o       <= s1_frac;
      edge_word_o  <= early_word_o;
    end
  end

  // R4: each warning is followed by an edge report
  p_early_then_edge_r4: assert property (@(posedge clk) disable iff (rst)
    early_o |=> edge_o);

  // R4: each edge report was preceded by a warning
  p_edge_had_early_r4: assert property (@(posedge clk) disable iff (rst)
    edge_o |-> $past(early_o));

  // R8: outputs quiet right after reset
  p_quiet_after_reset_r8: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!edge_o && !early_o && frac_o == '0));
endmodule

// File: rtl/nco_edge_gen.sv
module nco_edge_gen
  import nco_edge_pkg::*;
#(
  parameter int unsigned ACC_W  = NCO_ACC_W_DEF,
  parameter int unsigned FRAC_W = NCO_FRAC_W_DEF,
  localparam int unsigned SEL_W = $clog2(ACC_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic [ACC_W-1:0]  freq_word_i,
  input  logic [SEL_W-1:0]  tap_sel_i,
  output logic              early_o,
  output logic [ACC_W-1:0]  early_word_o,
  output logic              edge_o,
  output logic [FRAC_W-1:0] frac_o,
  output logic [ACC_W-1:0]  edge_word_o
);
  logic [ACC_W-1:0]  phase, word;
  logic [SEL_W-1:0]  tap;
  logic              toggle;
  logic [FRAC_W-1:0] frac_next;

  nco_phase_acc #(.ACC_W(ACC_W), .SEL_W(SEL_W)) acc_i (
    .clk(clk), .rst(rst), .load_i(load_i), .freq_word_i(freq_word_i),
    .tap_sel_i(tap_sel_i), .phase_o(phase), .word_o(word), .tap_o(tap)
  );

  nco_cross_detect #(.ACC_W(ACC_W), .SEL_W(SEL_W), .FRAC_W(FRAC_W)) det_i (
    .phase_i(phase), .word_i(word), .tap_i(tap),
    .toggle_o(toggle), .frac_o(frac_next)
  );

  nco_edge_pipe #(.ACC_W(ACC_W), .FRAC_W(FRAC_W)) pipe_i (
    .clk(clk), .rst(rst), .toggle_i(toggle), .frac_i(frac_next), .word_i(word),
    .early_o(early_o), .early_word_o(early_word_o), .edge_o(edge_o),
    .frac_o(frac_o), .edge_word_o(edge_word_o)
  );
endmodule

// File: tb/nco_edge_gen_tb_top.sv
module nco_edge_gen_tb_top;
  localparam int AW = 16;
  localparam int FW = 8;
  localparam int SW = 4;

  logic clk = 1'b0, rst = 1'b1, load = 1'b0;
  logic [AW-1:0] fword = '0;
  logic [SW-1:0] tsel = '0;
  logic early, edge_v;
  logic [AW-1:0] early_word, edge_word;
  logic [FW-1:0] frac;

  nco_edge_gen #(.ACC_W(AW), .FRAC_W(FW)) dut_i (
    .clk(clk), .rst(rst), .load_i(load), .freq_word_i(fword), .tap_sel_i(tsel),
    .early_o(early), .early_word_o(early_word), .edge_o(edge_v),
    .frac_o(frac), .edge_word_o(edge_word)
  );

  always #10 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // behavioural reference: records per update, oldest first
  typedef struct { bit ev; int fr; int wd; } rec_t;
  rec_t q[$];
  int m_phase, m_word, m_tap, np, low;
  rec_t r;
  bit model_on = 0;

  always @(posedge clk) begin
    if (rst) begin
      m_phase = 0; m_word = 0; m_tap = AW - 1;
      q.delete();
      r = '{0, 0, 0};
      q.push_back(r); q.push_back(r);
    end else begin
      np = (m_phase + m_word) % 65536;
      r.ev = (((np >> m_tap) & 1) != ((m_phase >> m_tap) & 1));
      low = np % (1 << m_tap);
      r.fr = (m_tap >= FW) ? (low >> (m_tap - FW)) : ((low << (FW - m_tap)) & 255);
      r.wd = m_word;
      q.push_back(r);
      while (q.size() > 2) void'(q.pop_front());
      m_phase = np;
      if (load) begin m_word = int'(fword); m_tap = int'(tsel); end
    end
    model_on = 1;
  end

  always @(negedge clk) begin
    if (model_on && !finished) begin
      check(early == q[1].ev, "R4 early", int'(early), int'(q[1].ev));
      check(int'(early_word) == q[1].wd, "R5 early word", int'(early_word), q[1].wd);
      check(edge_v == q[0].ev, "R2 edge", int'(edge_v), int'(q[0].ev));
      check(int'(frac) == q[0].fr, "R3 frac", int'(frac), q[0].fr);
      check(int'(edge_word) == q[0].wd, "R5 edge word", int'(edge_word), q[0].wd);
    end
  end

  task automatic do_load(input int w, input int t);
    @(negedge clk);
    load = 1'b1; fword = AW'(w); tsel = SW'(t);
    @(negedge clk);
    load = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk);
    check(!edge_v && !early && frac == '0 && edge_word == '0, "R8 reset outputs",
          int'({edge_v, early}), 0);
    rst = 1'b0;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    int f1, f2, cnt;
    repeat (3) @(negedge clk);
    check(!edge_v && !early && frac == '0, "R8 initial reset", int'({edge_v, early}), 0);
    rst = 1'b0;

    // R1: phase advance seen through the fraction (word 0x100, tap 15 -> +2 per clock)
    do_load(16'h0100, 15);
    repeat (5) @(negedge clk);
    f1 = int'(frac);
    @(negedge clk);
    f2 = int'(frac);
    check(f2 == ((f1 + 2) & 255), "R1 phase step", f2, (f1 + 2) & 255);
    repeat (300) @(negedge clk);

    do_load(16'h0123, 15);
    repeat (400) @(negedge clk);
    do_load(16'h0050, 11);
    repeat (200) @(negedge clk);
    do_load(16'h9000, 15);
    repeat (50) @(negedge clk);

    // tap 0, word 1: bit 0 changes on every update
    do_load(1, 0);
    repeat (3) @(negedge clk);
    check(edge_v == 1'b1 && frac == '0, "R2 tap zero every cycle", int'(edge_v), 1);
    repeat (20) @(negedge clk);

    // R7: inputs wiggle without load
    do_load(16'h0040, 13);
    repeat (4) @(negedge clk);
    for (int i = 0; i < 100; i++) begin
      fword = AW'(i * 977 + 5); tsel = SW'(i);
      @(negedge clk);
    end
    check(edge_word == 16'h0040, "R7 word unchanged", int'(edge_word), 16'h0040);

    // R6: load captured at edge e; first used by update at e+1
    @(negedge clk);
    load = 1'b1; fword = 16'h0333; tsel = 14;
    @(negedge clk);
    load = 1'b0;
    check(early_word == 16'h0040, "R6 old word still used", int'(early_word), 16'h0040);
    @(negedge clk);
    check(early_word == 16'h0333, "R6 new word in effect", int'(early_word), 16'h0333);
    repeat (100) @(negedge clk);

    // R9: edge count doubles per tap step
    do_reset();
    do_load(16'h0100, 12);
    repeat (4) @(negedge clk);
    cnt = 0;
    for (int i = 0; i < 512; i++) begin @(negedge clk); cnt += int'(edge_v); end
    check(cnt == 32, "R9 tap 12 count", cnt, 32);
    do_reset();
    do_load(16'h0100, 11);
    repeat (4) @(negedge clk);
    cnt = 0;
    for (int i = 0; i < 512; i++) begin @(negedge clk); cnt += int'(edge_v); end
    check(cnt == 64, "R9 tap 11 count", cnt, 64);

    // R8: reset in the middle of a run
    do_load(16'h7777, 15);
    repeat (30) @(negedge clk);
    do_reset();
    repeat (10) @(negedge clk);
    check(!edge_v && !early, "R8 no edge after reset with zero word", int'({edge_v, early}), 0);

    finished = 1;
    summary();
    $finish;
  end
endmodule